// File: doc/BRIEF.md
# Sensor Alarm Interrupt and Channel Ownership Unit

This block is a small register slave on an APB 3.0 bus. It watches a vector of level alarm lines from an on-chip sensor converter. Each alarm line passes through a synchronizer. The rising edge of the synchronized level sets a sticky status bit. Status bits that are not masked are combined into a single interrupt request. Software clears a status bit by writing a one to it. A further read-only register shows the synchronized alarm levels as they are now.

The block also holds one ownership bit for a shared serial command channel. Two requesters can drive that channel: an external JTAG-style port and the processor-side port. Only one of them owns it at a time. For each requester the block reports whether its request is granted or blocked. It also drives a select line that steers the channel.

Top module: `sensor_alarm_irq`

## Requirements
- R1: After reset, the ownership bit is 0 and the channel belongs to the JTAG-style requester. All mask bits are 1, all status bits are 0, and the interrupt is low.
- R2: Bit 0 of the configuration register (offset 0x0) is the ownership bit. Writing 1 to it gives the channel to the processor-side requester, and `chan_sel_cpu` goes high after that write. Writing 0 gives the channel back to the JTAG-style requester. Bits 31:1 read as 0.
- R3: A requester is granted only while it owns the channel. A request from the requester that does not own the channel is reported as blocked and is never granted. The two grants are never high together.
- R4: Each alarm input passes through a two-flop synchronizer. A rising edge of the synchronized level sets the matching bit of the status register (offset 0x4) two clock edges after the input is first sampled high. The bit stays set after the alarm drops.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a rising edge and a clearing write hit the same bit on the same clock edge, the bit ends up set.
- R6: The mask register (offset 0x8) holds one read/write bit per alarm. A mask bit of 1 keeps that alarm from raising the interrupt.
- R7: `irq` is the OR of all status bits whose mask bit is 0. It changes in the cycle after the register write or status change that causes it.
- R8: The raw register (offset 0xC) returns the synchronized alarm levels, with no latching and no masking. Unused upper bits read as 0.
- R9: `pready` is always 1. A write takes effect on the clock edge of its access phase. `prdata` carries the addressed register whenever `psel` is high and `pwrite` is low.
- R10: An unaligned offset, or an offset of 0x10 or above, reads as zero. It asserts `pslverr` in the access phase, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error for an unmapped offset |
| alarm_in | input | N_ALARMS | Asynchronous alarm levels from the sensor converter |
| irq | output | 1 | Combined interrupt request |
| jtag_req | input | 1 | JTAG-style requester wants the channel |
| cpu_req | input | 1 | Processor-side requester wants the channel |
| chan_sel_cpu | output | 1 | Channel steered to the processor side when high |
| jtag_grant | output | 1 | JTAG-style request granted |
| jtag_blocked | output | 1 | JTAG-style request refused |
| cpu_grant | output | 1 | Processor-side request granted |
| cpu_blocked | output | 1 | Processor-side request refused |

## Verification
A status bit that is set or cleared wrongly shows up on `irq` in the next cycle once that alarm is unmasked. It also shows up on `prdata` at the next status read. A synchronizer that loses or adds a stage moves the status set by one cycle, and the reference model, which compares every cycle, catches that offset. A wrong ownership bit shows at once on the select line and on both grant and blocked pairs, while a request is present.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned MAP_BYTES = 16;

    typedef enum logic [1:0] {
        REG_CFG = 2'd0,
        REG_STS = 2'd1,
        REG_MSK = 2'd2,
        REG_RAW = 2'd3
    } reg_sel_e;

    typedef enum logic {
        OWN_JTAG = 1'b0,
        OWN_CPU  = 1'b1
    } owner_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        logic     hit;
        reg_sel_e sel;
    } apb_op_t;

    function automatic apb_op_t decode_op(
        input logic        sel_i,
        input logic        enable_i,
        input logic        write_i,
        input logic [31:0] addr_i
    );
        apb_op_t op;
        op.hit = (addr_i[1:0] == 2'b00) && (addr_i < MAP_BYTES);
        op.sel = reg_sel_e'(addr_i[3:2]);
        op.rd  = sel_i && !write_i;
        op.wr  = sel_i && enable_i && write_i && op.hit;
        return op;
    endfunction

endpackage

// File: rtl/alarm_sync_rise.sv
module alarm_sync_rise #(
    parameter int unsigned N      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            logic [N-1:0] q;
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) q <= '0;
                    else     q <= raw_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) q <= '0;
                    else     q <= g_stage[g-1].q;
                end
            end
        end
    endgenerate

    assign level = g_stage[STAGES-1].q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/alarm_status_bank.sv
module alarm_status_bank #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] clr,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] status_q,
    output logic [N-1:0] mask_q,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '1;
        end else begin
            status_q <= (status_q & ~clr) | rise;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/chan_owner.sv
module chan_owner
    import alarm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_we,
    input  logic en_wdata,
    input  logic jtag_req,
    input  logic cpu_req,
    output logic chan_cpu,
    output logic jtag_grant,
    output logic jtag_blocked,
    output logic cpu_grant,
    output logic cpu_blocked
);
    owner_e owner_q;

    always_ff @(posedge clk) begin
        if (rst)        owner_q <= OWN_JTAG;
        else if (en_we) owner_q <= en_wdata ? OWN_CPU : OWN_JTAG;
    end

    assign chan_cpu     = (owner_q == OWN_CPU);
    assign jtag_grant   = jtag_req && (owner_q == OWN_JTAG);
    assign jtag_blocked = jtag_req && (owner_q != OWN_JTAG);
    assign cpu_grant    = cpu_req && (owner_q == OWN_CPU);
    assign cpu_blocked  = cpu_req && (owner_q != OWN_CPU);
endmodule

// File: rtl/sensor_alarm_irq.sv
module sensor_alarm_irq
    import alarm_irq_pkg::*;
#(
    parameter int unsigned N_ALARMS    = 8,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [DATA_W-1:0]   pwdata,
    output logic [DATA_W-1:0]   prdata,
    output logic                pready,
    output logic                pslverr,
    input  logic [N_ALARMS-1:0] alarm_in,
    output logic                irq,
    input  logic                jtag_req,
    input  logic                cpu_req,
    output logic                chan_sel_cpu,
    output logic                jtag_grant,
    output logic                jtag_blocked,
    output logic                cpu_grant,
    output logic                cpu_blocked
);
    apb_op_t              op;
    logic [N_ALARMS-1:0]  lvl;
    logic [N_ALARMS-1:0]  rise;
    logic [N_ALARMS-1:0]  clr_vec;
    logic [N_ALARMS-1:0]  status_q;
    logic [N_ALARMS-1:0]  mask_q;
    logic                 mask_we;
    logic                 cfg_we;
    logic                 chan_cpu;
    logic                 unused_wdata;

    assign op      = decode_op(psel, penable, pwrite, 32'(paddr));
    assign cfg_we  = op.wr && (op.sel == REG_CFG);
    assign mask_we = op.wr && (op.sel == REG_MSK);
    assign clr_vec = (op.wr && (op.sel == REG_STS)) ? pwdata[N_ALARMS-1:0] : '0;
    assign unused_wdata = ^pwdata;

    alarm_sync_rise #(.N(N_ALARMS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (alarm_in),
        .level  (lvl),
        .rise   (rise)
    );

    alarm_status_bank #(.N(N_ALARMS)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .rise       (rise),
        .clr        (clr_vec),
        .mask_we    (mask_we),
        .mask_wdata (pwdata[N_ALARMS-1:0]),
        .status_q   (status_q),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    chan_owner u_owner (
        .clk          (clk),
        .rst          (rst),
        .en_we        (cfg_we),
        .en_wdata     (pwdata[0]),
        .jtag_req     (jtag_req),
        .cpu_req      (cpu_req),
        .chan_cpu     (chan_cpu),
        .jtag_grant   (jtag_grant),
        .jtag_blocked (jtag_blocked),
        .cpu_grant    (cpu_grant),
        .cpu_blocked  (cpu_blocked)
    );

    assign chan_sel_cpu = chan_cpu;

    always_comb begin
        prdata = '0;
        if (op.rd && op.hit) begin
            unique case (op.sel)
                REG_CFG: prdata = DATA_W'(chan_cpu);
                REG_STS: prdata = DATA_W'(status_q);
                REG_MSK: prdata = DATA_W'(mask_q);
                REG_RAW: prdata = DATA_W'(lvl);
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = psel && penable && !op.hit;
endmodule

// File: rtl/alarm_irq_checker.sv
module alarm_irq_checker #(
    parameter int unsigned N      = 8,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       prdata,
    input logic              pready,
    input logic              pslverr,
    input logic              irq,
    input logic [N-1:0]      status_q,
    input logic [N-1:0]      mask_q,
    input logic              chan_cpu,
    input logic              jtag_req,
    input logic              cpu_req,
    input logic              jtag_grant,
    input logic              jtag_blocked,
    input logic              cpu_grant,
    input logic              cpu_blocked
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> ((&mask_q) && (status_q == '0) && !chan_cpu));

    a_r3_one_grant: assert property (@(posedge clk) disable iff (rst)
        !(jtag_grant && cpu_grant));

    a_r3_cpu_refused: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !chan_cpu) |-> (cpu_blocked && !cpu_grant));

    a_r3_jtag_refused: assert property (@(posedge clk) disable iff (rst)
        (jtag_req && chan_cpu) |-> (jtag_blocked && !jtag_grant));

    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        !(psel && penable && pwrite && (paddr == ADDR_W'(4)))
        |=> ((status_q & $past(status_q)) == $past(status_q)));

    a_r6_all_masked: assert property (@(posedge clk) disable iff (rst)
        (&mask_q) |-> !irq);

    a_r7_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status_q != '0));

    a_r9_ready: assert property (@(posedge clk) disable iff (rst)
        pready);

    a_r10_err_zero: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (prdata == '0));
endmodule

bind sensor_alarm_irq alarm_irq_checker #(.N(N_ALARMS), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .prdata       (prdata),
    .pready       (pready),
    .pslverr      (pslverr),
    .irq          (irq),
    .status_q     (status_q),
    .mask_q       (mask_q),
    .chan_cpu     (chan_cpu),
    .jtag_req     (jtag_req),
    .cpu_req      (cpu_req),
    .jtag_grant   (jtag_grant),
    .jtag_blocked (jtag_blocked),
    .cpu_grant    (cpu_grant),
    .cpu_blocked  (cpu_blocked)
);

// File: tb/sensor_alarm_irq_bench.sv
`timescale 1ns/1ps
module sensor_alarm_irq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq;
    logic [7:0]  alarm_in = '0;
    logic        jtag_req = 1'b0, cpu_req = 1'b0;
    logic        chan_sel_cpu, jtag_grant, jtag_blocked, cpu_grant, cpu_blocked;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference state
    logic [7:0] h0 = '0, h1 = '0, h2 = '0;
    logic [7:0] m_sts = '0, m_msk = 8'hFF;
    logic       m_en = 1'b0;

    always #2 clk = ~clk;

    sensor_alarm_irq u_sensor_alarm_irq (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .alarm_in(alarm_in), .irq(irq),
        .jtag_req(jtag_req), .cpu_req(cpu_req), .chan_sel_cpu(chan_sel_cpu),
        .jtag_grant(jtag_grant), .jtag_blocked(jtag_blocked),
        .cpu_grant(cpu_grant), .cpu_blocked(cpu_blocked)
    );

    function automatic bit addr_ok();
        return (paddr[1:0] == 2'b00) && (paddr < 5'd16);
    endfunction

    function automatic logic [31:0] exp_rdata();
        if (!(psel && !pwrite && addr_ok())) return 32'h0;
        case (paddr[3:2])
            2'd0:    return {31'h0, m_en};
            2'd1:    return {24'h0, m_sts};
            2'd2:    return {24'h0, m_msk};
            default: return {24'h0, h1};
        endcase
    endfunction

    function automatic string rd_tag();
        if (!addr_ok()) return "R10";
        case (paddr[3:2])
            2'd0:    return "R2";
            2'd1:    return "R4";
            2'd2:    return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [7:0] clr;
        bit wr;
        if (rst) begin
            h0 = '0; h1 = '0; h2 = '0;
            m_sts = '0; m_msk = 8'hFF; m_en = 1'b0;
        end else begin
            wr  = psel && penable && pwrite && addr_ok();
            clr = (wr && paddr[3:2] == 2'd1) ? pwdata[7:0] : 8'h0;
            m_sts = (m_sts & ~clr) | (h1 & ~h2);
            if (wr && paddr[3:2] == 2'd2) m_msk = pwdata[7:0];
            if (wr && paddr[3:2] == 2'd0) m_en  = pwdata[0];
            h2 = h1; h1 = h0; h0 = alarm_in;
        end
    endtask

    // Compare all outputs, then advance one clock against the model.
    task automatic step(input string tag = "");
        #1;
        if (!rst) begin
            check("R9", "pready", {31'h0, pready}, 32'h1);
            check("R10", "pslverr", {31'h0, pslverr},
                  {31'h0, psel && penable && !addr_ok()});
            check("R7", "irq", {31'h0, irq}, {31'h0, |(m_sts & ~m_msk)});
            check("R2", "chan_sel_cpu", {31'h0, chan_sel_cpu}, {31'h0, m_en});
            check("R3", "jtag_grant", {31'h0, jtag_grant}, {31'h0, jtag_req && !m_en});
            check("R3", "jtag_blocked", {31'h0, jtag_blocked}, {31'h0, jtag_req && m_en});
            check("R3", "cpu_grant", {31'h0, cpu_grant}, {31'h0, cpu_req && m_en});
            check("R3", "cpu_blocked", {31'h0, cpu_blocked}, {31'h0, cpu_req && !m_en});
            check(rd_tag(), "prdata", prdata, exp_rdata());
            if (tag != "") check(tag, "readback", prdata, exp_rdata());
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic apb_write(input logic [4:0] a, input logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        step();
        penable = 1'b1;
        step();
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [4:0] a, input string tag);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        step();
        penable = 1'b1;
        step(tag);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle(3);
        rst = 1'b0;

        // R1: reset values
        apb_read(5'h08, "R1");
        apb_read(5'h04, "R1");
        apb_read(5'h00, "R1");
        check("R1", "irq after reset", {31'h0, irq}, 32'h0);

        // R2 / R3: ownership handover and back
        jtag_req = 1'b1; cpu_req = 1'b1;
        idle(2);
        apb_write(5'h00, 32'h1);
        idle(2);
        apb_read(5'h00, "R2");
        apb_write(5'h00, 32'h2);
        idle(1);
        apb_read(5'h00, "R2");
        jtag_req = 1'b0;
        idle(1);
        cpu_req = 1'b0;

        // R4 / R8: latch on edge, stays after drop; raw shows live level
        alarm_in = 8'h05;
        idle(4);
        alarm_in = 8'h30;
        idle(3);
        apb_read(5'h04, "R4");
        apb_read(5'h0C, "R8");
        alarm_in = 8'h00;
        idle(3);
        apb_read(5'h0C, "R8");

        // R6 / R7: unmask and mask again
        apb_write(5'h08, 32'hFE);
        idle(1);
        check("R7", "irq unmasked", {31'h0, irq}, 32'h1);
        apb_write(5'h08, 32'hCA);
        apb_read(5'h08, "R6");
        apb_write(5'h08, 32'hFF);
        idle(1);
        check("R6", "irq masked", {31'h0, irq}, 32'h0);

        // R5: write 0 keeps, write 1 clears
        apb_write(5'h04, 32'h0);
        apb_read(5'h04, "R5");
        apb_write(5'h04, 32'h1);
        apb_read(5'h04, "R5");

        // R5: set and clear on the same edge, set wins
        apb_write(5'h04, 32'hFF);
        alarm_in = 8'h02;
        step();
        apb_write(5'h04, 32'h02);
        apb_read(5'h04, "R5");
        alarm_in = 8'h00;

        // R10: unmapped and unaligned offsets
        apb_read(5'h10, "R10");
        apb_read(5'h06, "R10");
        apb_write(5'h12, 32'h0);
        apb_write(5'h18, 32'h1);
        apb_read(5'h08, "R10");
        apb_read(5'h00, "R10");

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            alarm_in = 8'($urandom);
            jtag_req = 1'($urandom);
            cpu_req  = 1'($urandom);
            case ($urandom % 4)
                0:       apb_write(5'($urandom % 20), $urandom);
                1:       apb_read(5'($urandom % 20), "");
                default: step();
            endcase
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule